// File: doc/BRIEF.md
# Reset Controller with Selectable Watchdog Scope

This block turns four reset causes into two reset outputs for a system where the processor and the peripherals can be reset apart. The four causes are a power-on reset, the external reset pad, a software request and a window-watchdog expiry. One output is a CPU-only reset. The other is a full system reset that also clears the peripherals. A software request always leads to a full system reset. A watchdog expiry leads to one or the other, depending on a scope bit. Software can set the scope bit. Hardware clears it whenever a system reset happens.

Each full system reset also pulls the open-drain reset pad low for a fixed number of clock cycles. The pad is read back through a synchronizer. The block ignores the pad while it is sequencing a reset, so its own pulse is never counted again as an external request. The block keeps one sticky flag per cause so that boot code can find out why it restarted. Software can clear all the flags at once with a single remove strobe.

Top module: `rst_scope_ctrl`

## Requirements
- R1: Power-on reset (`por_n` low) asserts both reset outputs and clears the scope bit. It sets the flag vector to 4'b0001. The flag bits are: bit 0 power-on, bit 1 external pad, bit 2 software, bit 3 watchdog.
- R2: A watchdog expiry with the scope bit clear asserts only `cpu_rst_n_o`. It stays low in the request cycle and for CPU_RST_CYC further cycles. `sys_rst_n_o` stays high and the pad is not driven.
- R3: A watchdog expiry with the scope bit set starts a full system reset.
- R4: A software request always starts a full system reset, whatever the scope bit holds.
- R5: A system reset started by software or by the watchdog drives `pad_oe_o` for exactly PULSE_CYC cycles. PULSE_CYC is at least 20. This self-driven pulse never sets the pad flag. A CPU-only reset never drives the pad.
- R6: A `scope_set_i` strobe sets the scope bit. Any cycle in which the system reset is asserted clears it, and the clear wins over a set in the same cycle.
- R7: Each flag is set when its cause is accepted. Flags survive system and CPU resets. A `flag_rmv_i` strobe clears all flags. A cause accepted in the same cycle as the strobe leaves its own flag set.
- R8: A low level on the pad, seen through a two-flop synchronizer while the block is idle or in a CPU-only reset, starts a system reset. The block does not drive the pad for this cause. It holds the reset until the synchronized pad reads high again, and it sets the pad flag.
- R9: A request asserts the reset outputs in the same cycle, through logic that does not wait for a clock edge. Release is synchronous: `sys_rst_n_o` rises first and `cpu_rst_n_o` rises exactly one cycle later.
- R10: Software and watchdog requests that arrive while a system reset is already in progress are ignored and set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pad_n_i | input | 1 | Level sensed on the external reset pad, active low |
| sw_req_i | input | 1 | Software reset request strobe |
| wdg_expire_i | input | 1 | Watchdog timeout strobe |
| scope_set_i | input | 1 | Strobe that sets the watchdog scope bit |
| flag_rmv_i | input | 1 | Strobe that clears all reset-cause flags |
| sys_rst_n_o | output | 1 | Full system reset, active low |
| cpu_rst_n_o | output | 1 | CPU reset, active low |
| pad_oe_o | output | 1 | Open-drain enable that pulls the pad low |
| scope_o | output | 1 | Current watchdog scope bit |
| flags_o | output | 4 | Sticky reset-cause flags |

## Verification
The bench targets the routing of a watchdog expiry. If the design ignored the scope bit, peripherals would survive a watchdog reset, or a CPU-only reset would pulse the pad. It also targets the case where the self-driven pad pulse is sampled back. If the design did not mask that sampling, it would set the pad flag or reset again in a loop. Further corner cases are:
- a set and a clear arriving together on the flags or the scope bit, where the wrong priority would lose a cause or leave the scope armed;
- requests that arrive during a reset already in progress, which would leave stray flags;
- the release order of the two outputs, which would let the CPU run while the peripherals are still held.

// File: rtl/rstc_pkg.sv
`timescale 1ns/1ps
package rstc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_CPU     = 3'd1,
    ST_PULSE   = 3'd2,
    ST_WAITPAD = 3'd3,
    ST_CPUREL  = 3'd4
  } rst_state_e;

  localparam int NUM_FLAGS = 4;
  localparam int FLG_POR   = 0;
  localparam int FLG_PAD   = 1;
  localparam int FLG_SW    = 2;
  localparam int FLG_WDG   = 3;

endpackage

// File: rtl/rstc_sync.sv
`timescale 1ns/1ps
module rstc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rstc_seq.sv
`timescale 1ns/1ps
module rstc_seq
  import rstc_pkg::*;
#(
  parameter int PULSE_CYC = 20,
  parameter int CPU_CYC   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pad_hi_i,
  input  logic                 sw_req_i,
  input  logic                 wdg_i,
  input  logic                 scope_i,
  output logic                 sys_hold_o,
  output logic                 cpu_hold_o,
  output logic                 pad_drv_o,
  output logic                 sys_trig_o,
  output logic                 cpu_trig_o,
  output logic [NUM_FLAGS-1:0] hit_o
);

  localparam int CNT_MAX = (PULSE_CYC > CPU_CYC) ? PULSE_CYC : CPU_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] CPU_LD   = CNT_W'(CPU_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W:0]   PULSE_LEN = (CNT_W + 1)'(PULSE_CYC);

  rst_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             sys_hold_q, sys_hold_d;
  logic             cpu_hold_q, cpu_hold_d;
  logic             pad_drv_q, pad_drv_d;

  logic accept, sw_t, wdg_sys_t, wdg_cpu_t, pad_t, drive_t, sys_t, cpu_t;

  // request qualification
  always_comb begin
    accept    = (state_q == ST_IDLE) || (state_q == ST_CPU);
    sw_t      = accept & sw_req_i;
    wdg_sys_t = accept & wdg_i & scope_i;
    wdg_cpu_t = accept & wdg_i & ~scope_i;
    pad_t     = accept & ~pad_hi_i;
    drive_t   = sw_t | wdg_sys_t;
    sys_t     = drive_t | pad_t;
    cpu_t     = wdg_cpu_t & ~sys_t;
  end

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE, ST_CPU: begin
        if (drive_t) begin
          state_d = ST_PULSE;
          cnt_d   = PULSE_LD;
        end else if (pad_t) begin
          state_d = ST_WAITPAD;
        end else if (cpu_t) begin
          state_d = ST_CPU;
          cnt_d   = CPU_LD;
        end else if (state_q == ST_CPU) begin
          if (cnt_q == '0) state_d = ST_IDLE;
          else             cnt_d   = cnt_q - CNT_ONE;
        end
      end
      ST_PULSE: begin
        if (cnt_q == '0) state_d = ST_WAITPAD;
        else             cnt_d   = cnt_q - CNT_ONE;
      end
      ST_WAITPAD: begin
        if (pad_hi_i) state_d = ST_CPUREL;
      end
      ST_CPUREL: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
    cnt_en     = (cnt_d != cnt_q);
    sys_hold_d = (state_d == ST_PULSE) || (state_d == ST_WAITPAD);
    cpu_hold_d = sys_hold_d || (state_d == ST_CPU) || (state_d == ST_CPUREL);
    pad_drv_d  = (state_d == ST_PULSE);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_WAITPAD;
      sys_hold_q <= 1'b1;
      cpu_hold_q <= 1'b1;
      pad_drv_q  <= 1'b0;
    end else begin
      state_q    <= state_d;
      sys_hold_q <= sys_hold_d;
      cpu_hold_q <= cpu_hold_d;
      pad_drv_q  <= pad_drv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign sys_hold_o = sys_hold_q;
  assign cpu_hold_o = cpu_hold_q;
  assign pad_drv_o  = pad_drv_q;
  assign sys_trig_o = sys_t;
  assign cpu_trig_o = cpu_t;

  always_comb begin
    hit_o          = '0;
    hit_o[FLG_PAD] = pad_t;
    hit_o[FLG_SW]  = sw_t;
    hit_o[FLG_WDG] = wdg_sys_t | wdg_cpu_t;
  end

  // checker: length of the pad pulse
  logic [CNT_W:0] pulse_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pulse_len_q <= '0;
    else if (pad_drv_q) pulse_len_q <= pulse_len_q + 1'b1;
    else                pulse_len_q <= '0;
  end

  // R5
  pad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pad_drv_q) |-> (pulse_len_q == PULSE_LEN));

  // R5
  pad_sys_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_drv_q |-> (sys_hold_q && cpu_hold_q));

  // R9
  rel_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_hold_q) |-> cpu_hold_q);

  // R9
  rel_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_hold_q) |=> !cpu_hold_q);

  // R2
  wdg_cpu_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdg_i && !scope_i && !sw_req_i && pad_hi_i && !sys_hold_q) |=> (!sys_hold_q && cpu_hold_q));

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_hold_q && state_q != ST_CPUREL) |-> (hit_o == '0));

endmodule

// File: rtl/rstc_flags.sv
`timescale 1ns/1ps
module rstc_flags
  import rstc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] hit_i,
  input  logic                 rmv_i,
  input  logic                 sys_active_i,
  input  logic                 scope_set_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic                 scope_o
);

  localparam logic [NUM_FLAGS-1:0] POR_FLAGS = NUM_FLAGS'(1) << FLG_POR;

  logic [NUM_FLAGS-1:0] flags_q, flags_d;
  logic                 flags_en;
  logic                 scope_q, scope_d;
  logic                 scope_en;

  always_comb begin
    flags_d  = (flags_q & ~{NUM_FLAGS{rmv_i}}) | hit_i;
    flags_en = rmv_i | (|hit_i);
    scope_d  = sys_active_i ? 1'b0 : 1'b1;
    scope_en = sys_active_i | scope_set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= POR_FLAGS;
    else if (flags_en) flags_q <= flags_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        scope_q <= 1'b0;
    else if (scope_en) scope_q <= scope_d;
  end

  assign flags_o = flags_q;
  assign scope_o = scope_q;

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i != '0) |=> ((flags_q & $past(hit_i)) == $past(hit_i)));

  // R7
  rmv_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rmv_i && hit_i == '0) |=> (flags_q == '0));

  // R6
  scope_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_active_i |=> !scope_q);

  // R6
  scope_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scope_set_i && !sys_active_i) |=> scope_q);

endmodule

// File: rtl/rst_scope_ctrl.sv
`timescale 1ns/1ps
module rst_scope_ctrl
  import rstc_pkg::*;
#(
  parameter int PULSE_CYC   = 20,
  parameter int CPU_RST_CYC = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 pad_n_i,
  input  logic                 sw_req_i,
  input  logic                 wdg_expire_i,
  input  logic                 scope_set_i,
  input  logic                 flag_rmv_i,
  output logic                 sys_rst_n_o,
  output logic                 cpu_rst_n_o,
  output logic                 pad_oe_o,
  output logic                 scope_o,
  output logic [NUM_FLAGS-1:0] flags_o
);

  logic                 pad_hi;
  logic                 sys_hold, cpu_hold, sys_trig, cpu_trig;
  logic [NUM_FLAGS-1:0] hit;
  logic                 scope;
  logic                 sys_active;

  rstc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pad_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d_i   (pad_n_i),
    .q_o   (pad_hi)
  );

  rstc_seq #(.PULSE_CYC(PULSE_CYC), .CPU_CYC(CPU_RST_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (por_n),
    .pad_hi_i   (pad_hi),
    .sw_req_i   (sw_req_i),
    .wdg_i      (wdg_expire_i),
    .scope_i    (scope),
    .sys_hold_o (sys_hold),
    .cpu_hold_o (cpu_hold),
    .pad_drv_o  (pad_oe_o),
    .sys_trig_o (sys_trig),
    .cpu_trig_o (cpu_trig),
    .hit_o      (hit)
  );

  assign sys_active = sys_hold | sys_trig;

  rstc_flags u_flags (
    .clk          (clk),
    .rst_n        (por_n),
    .hit_i        (hit),
    .rmv_i        (flag_rmv_i),
    .sys_active_i (sys_active),
    .scope_set_i  (scope_set_i),
    .flags_o      (flags_o),
    .scope_o      (scope)
  );

  assign scope_o     = scope;
  assign sys_rst_n_o = ~sys_active;
  assign cpu_rst_n_o = ~(cpu_hold | sys_trig | cpu_trig);

  // R9
  cpu_follows_sys_chk: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst_n_o |-> !cpu_rst_n_o);

endmodule

// File: tb/sim_rst_scope_ctrl.sv
`timescale 1ns/1ps
module sim_rst_scope_ctrl;

  localparam int P = 20;
  localparam int C = 8;

  typedef struct packed {
    logic       pre_scope;
    logic       sw;
    logic       wdg;
    logic       ext;
    logic       exp_sys;
    logic [5:0] exp_pad;
    logic [3:0] exp_flags;
    logic       exp_scope;
    logic [5:0] exp_cpu;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'd0,  4'b1000, 1'b0, 6'd9},
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 6'd20, 4'b1000, 1'b0, 6'd0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 6'd20, 4'b0100, 1'b0, 6'd0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 6'd0,  4'b0010, 1'b0, 6'd0},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 6'd20, 4'b0100, 1'b0, 6'd0},
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 6'd20, 4'b1100, 1'b0, 6'd0}
  };

  logic       clk = 1'b0;
  logic       por_n, sw, wdg, scope_set, rmv, ext_low;
  logic       pad_n;
  logic       sys_rst_n, cpu_rst_n, pad_oe, scope;
  logic [3:0] flags;
  int         tests = 0;
  int         fails = 0;

  always #2.5 clk = ~clk;

  assign pad_n = ~(pad_oe | ext_low);

  rst_scope_ctrl #(.PULSE_CYC(P), .CPU_RST_CYC(C), .SYNC_STAGES(2)) u0 (
    .clk          (clk),
    .por_n        (por_n),
    .pad_n_i      (pad_n),
    .sw_req_i     (sw),
    .wdg_expire_i (wdg),
    .scope_set_i  (scope_set),
    .flag_rmv_i   (rmv),
    .sys_rst_n_o  (sys_rst_n),
    .cpu_rst_n_o  (cpu_rst_n),
    .pad_oe_o     (pad_oe),
    .scope_o      (scope),
    .flags_o      (flags)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("[TB] FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_flags();
    rmv = 1'b1;
    @(negedge clk);
    rmv = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int    pad_cnt = 0;
    int    cpu_cnt = 0;
    bit    sys_seen = 0;
    bit    cpu_seen = 0;
    int    sys_rel = -1;
    int    cpu_rel = -1;
    bit    first_low = 0;
    string tag;
    tag = v.ext ? "R8" : (v.sw ? "R4" : (v.pre_scope ? "R3" : "R2"));
    clear_flags();
    if (v.pre_scope) begin
      scope_set = 1'b1;
      @(negedge clk);
      scope_set = 1'b0;
    end
    sw = v.sw; wdg = v.wdg; ext_low = v.ext;
    for (int i = 0; i < 60; i++) begin
      #1;
      if (i == 0) first_low = !sys_rst_n;
      if (!sys_rst_n) sys_seen = 1;
      else if (sys_seen && sys_rel < 0) sys_rel = i;
      if (!cpu_rst_n) begin cpu_seen = 1; cpu_cnt++; end
      else if (cpu_seen && cpu_rel < 0) cpu_rel = i;
      if (pad_oe) pad_cnt++;
      @(negedge clk);
      sw = 1'b0; wdg = 1'b0;
      if (i == 4) ext_low = 1'b0;
    end
    chk($sformatf("%s vec%0d system reset seen", tag, idx), int'(sys_seen), int'(v.exp_sys));
    chk($sformatf("R5 vec%0d pad pulse cycles", idx), pad_cnt, int'(v.exp_pad));
    chk($sformatf("R7 vec%0d flags", idx), int'(flags), int'(v.exp_flags));
    chk($sformatf("R6 vec%0d scope", idx), int'(scope), int'(v.exp_scope));
    if (v.exp_sys) begin
      chk($sformatf("R9 vec%0d cpu release gap", idx), cpu_rel - sys_rel, 1);
      if (!v.ext) chk($sformatf("R9 vec%0d same-cycle assertion", idx), int'(first_low), 1);
    end
    if (v.exp_cpu != 0)
      chk($sformatf("R2 vec%0d cpu reset cycles", idx), cpu_cnt, int'(v.exp_cpu));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("[TB] FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    por_n = 1'b0; sw = 1'b0; wdg = 1'b0; scope_set = 1'b0; rmv = 1'b0; ext_low = 1'b0;
    idle(3);
    #1;
    chk("R1 sys reset held at power-on", int'(sys_rst_n), 0);
    chk("R1 cpu reset held at power-on", int'(cpu_rst_n), 0);
    @(negedge clk);
    por_n = 1'b1;
    idle(10);
    chk("R1 flags after power-on", int'(flags), 1);
    chk("R1 scope after power-on", int'(scope), 0);
    chk("R1 cpu released after power-on", int'(cpu_rst_n), 1);

    for (int k = 0; k < NV; k++) run_vec(VECS[k], k);

    // R7: set wins over a simultaneous clear
    clear_flags();
    rmv = 1'b1; sw = 1'b1;
    @(negedge clk);
    rmv = 1'b0; sw = 1'b0;
    idle(60);
    chk("R7 set beats clear", int'(flags), 4'b0100);
    clear_flags();
    #1;
    chk("R7 remove clears all", int'(flags), 0);

    // R6: set alone, then set with a software reset in the same cycle
    @(negedge clk);
    scope_set = 1'b1;
    @(negedge clk);
    scope_set = 1'b0;
    #1;
    chk("R6 scope set", int'(scope), 1);
    @(negedge clk);
    scope_set = 1'b1; sw = 1'b1;
    @(negedge clk);
    scope_set = 1'b0; sw = 1'b0;
    idle(60);
    chk("R6 clear wins over set", int'(scope), 0);

    // R10: requests during a running system reset
    clear_flags();
    sw = 1'b1;
    @(negedge clk);
    sw = 1'b0;
    idle(3);
    wdg = 1'b1;
    @(negedge clk);
    wdg = 1'b0;
    idle(60);
    chk("R10 busy request ignored", int'(flags), 4'b0100);

    // R1: power-on in mid-run resets flags and scope
    scope_set = 1'b1;
    @(negedge clk);
    scope_set = 1'b0;
    por_n = 1'b0;
    idle(2);
    por_n = 1'b1;
    idle(10);
    chk("R1 flags after second power-on", int'(flags), 1);
    chk("R1 scope after second power-on", int'(scope), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule